// File: doc/BRIEF.md
# ADC Reference Saturation Calibration Loop

This block is a slow digital control loop that sits beside a pair of low-resolution I and Q sample converters. Each sample clock it decides, for each channel, whether the code sits on a rail: the lowest or the highest code. It adds up these rail hits over a long fixed window of sample clocks. When the window closes, it compares the total with a lower and an upper threshold and moves a reference-adjust code by at most one step. An external reference DAC or switched resistor network applies this code to set the converters' full-scale range.

If the signal hits the rails too often, the code steps up and the range widens. If it hits them too rarely, the code steps down and the range narrows. A total inside the threshold band leaves the code alone, which gives the loop a dead band. The code is clamped to a window that corresponds to about ±4 dB of gain drift. Because the default window is 2^20 sample clocks, or about 24 ms at 44 MHz, and each window moves the code by at most one step, the loop tracks only drift over seconds and cannot act as an AGC.

Top module: `adc_ref_cal`

## Requirements
- R1: A sample counts as saturated when its 3-bit code is 000 or 111, on the I input and on the Q input independently. Every other code (001 to 110) adds nothing to the count.
- R2: The count covers exactly 2^WIN_LOG2 consecutive sample clocks and sums the hits of both channels, so it ranges from 0 to 2·2^WIN_LOG2. No sample falls outside a window and none is counted twice.
- R3: A window total strictly greater than `thr_hi` raises `ref_code` by one.
- R4: A window total strictly less than `thr_lo` lowers `ref_code` by one.
- R5: A window total with `thr_lo` ≤ total ≤ `thr_hi` leaves `ref_code` unchanged. Both bounds are inclusive.
- R6: `ref_code` never exceeds REF_MAX (default 24) and does not wrap when the loop asks for more range.
- R7: `ref_code` never falls below REF_MIN (default 8), which protects the smallest reference level, and does not wrap.
- R8: While `rst_n` is low, `ref_code` equals REF_MID (default 16). The first window holds the samples presented at the first 2^WIN_LOG2 rising clock edges after `rst_n` goes high.
- R9: `ref_code` changes only on the clock edge that follows the capture of a window's last sample, by at most one step. It then holds for the next whole window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, twice the chip rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_code | input | 3 | In-phase converter sample code |
| q_code | input | 3 | Quadrature converter sample code |
| thr_lo | input | CNT_W (WIN_LOG2+2) | Lower window-count threshold |
| thr_hi | input | CNT_W (WIN_LOG2+2) | Upper window-count threshold |
| ref_code | output | REF_W (5) | Reference-adjust code for the external DAC |

## Verification
The assertions assume that `thr_lo` and `thr_hi` stay constant while the loop runs and that `thr_lo` does not exceed `thr_hi`. They also assume that both sample codes are always known values. The bench sets the thresholds once before reset is released and never changes them. It drives only defined codes, changing them on the falling clock edge. It shortens the window through the WIN_LOG2 parameter, so that many windows, clamping at both limits, and a reset in the middle of a window all fit in a short run.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    // Number of converter channels observed (I and Q).
    localparam int unsigned CAL_LANES = 2;

    // Decision taken at the end of a measurement window.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

endpackage

// File: rtl/cal_sat_detect.sv
// Flags rail codes per lane and registers the flags (one pipeline stage).
module cal_sat_detect #(
    parameter int unsigned SAMPLE_W = 3,
    parameter int unsigned LANES    = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LANES*SAMPLE_W-1:0]    codes,
    output logic [LANES-1:0]             flags,
    output logic                         valid
);

    typedef struct packed {
        logic [LANES-1:0] flags;
        logic             valid;
    } det_t;

    det_t det_d, det_q;

    logic [SAMPLE_W-1:0] lane_code [LANES];
    logic [LANES-1:0]    rail;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_code[g] = codes[g*SAMPLE_W +: SAMPLE_W];
        assign rail[g]      = (lane_code[g] == '0) || (lane_code[g] == '1);

        // R1: a rail code at the input must appear as a flag one clock later.
        assert_rail_seen_R1: assert property (@(posedge clk) disable iff (!rst_n)
            ((lane_code[g] == '0) || (lane_code[g] == '1)) |=> det_q.flags[g]);

        // R1: an interior code must never raise the flag.
        assert_mid_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
            ((lane_code[g] != '0) && (lane_code[g] != '1)) |=> !det_q.flags[g]);
    end

    always_comb begin
        det_d       = det_q;
        det_d.flags = rail;
        det_d.valid = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    assign flags = det_q.flags;
    assign valid = det_q.valid;

endmodule

// File: rtl/cal_window_acc.sv
// Counts valid sample clocks and accumulates rail flags over a 2^WIN_LOG2 window.
module cal_window_acc #(
    parameter int unsigned WIN_LOG2 = 20,
    parameter int unsigned LANES    = 2,
    parameter int unsigned CNT_W    = WIN_LOG2 + $clog2(LANES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] flags,
    input  logic             valid,
    output logic             win_end,
    output logic [CNT_W-1:0] win_total
);

    localparam logic [WIN_LOG2-1:0] WIN_LAST  = {WIN_LOG2{1'b1}};
    localparam logic [CNT_W-1:0]    LANES_C   = CNT_W'(LANES);
    localparam logic [CNT_W-1:0]    TOTAL_MAX = CNT_W'(LANES) << WIN_LOG2;

    typedef struct packed {
        logic [WIN_LOG2-1:0] pos;
        logic [CNT_W-1:0]    acc;
    } win_t;

    win_t win_d, win_q;

    logic [CNT_W-1:0] inc;
    logic             last;

    always_comb begin
        inc = '0;
        for (int l = 0; l < int'(LANES); l++) begin
            inc = inc + CNT_W'(flags[l]);
        end
    end

    assign last      = valid && (win_q.pos == WIN_LAST);
    assign win_total = win_q.acc + inc;

    always_comb begin
        win_d = win_q;
        if (valid) begin
            win_d.pos = win_q.pos + 1'b1;
            if (last) begin
                win_d.acc = '0;
            end else begin
                win_d.acc = win_total;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign win_end = last;

    // R2: never more hits than lanes times samples already counted.
    assert_acc_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win_q.acc <= (LANES_C * CNT_W'(win_q.pos)));

    // R2: a closing total stays within the full-window maximum.
    assert_total_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |-> (win_total <= TOTAL_MAX));

endmodule

// File: rtl/cal_ref_step.sv
// Compares a window total with the thresholds and steps the clamped reference code.
module cal_ref_step
    import adc_cal_pkg::*;
#(
    parameter int unsigned CNT_W   = 22,
    parameter int unsigned REF_W   = 5,
    parameter int unsigned REF_MIN = 8,
    parameter int unsigned REF_MAX = 24,
    parameter int unsigned REF_MID = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_end,
    input  logic [CNT_W-1:0] win_total,
    input  logic [CNT_W-1:0] thr_lo,
    input  logic [CNT_W-1:0] thr_hi,
    output logic [REF_W-1:0] ref_code
);

    localparam logic [REF_W-1:0] MIN_C = REF_W'(REF_MIN);
    localparam logic [REF_W-1:0] MAX_C = REF_W'(REF_MAX);
    localparam logic [REF_W-1:0] MID_C = REF_W'(REF_MID);

    typedef struct packed {
        logic [REF_W-1:0] lvl;
    } ref_t;

    ref_t  ref_d, ref_q;
    step_e step;

    always_comb begin
        if (win_total > thr_hi) begin
            step = STEP_UP;
        end else if (win_total < thr_lo) begin
            step = STEP_DOWN;
        end else begin
            step = STEP_HOLD;
        end
    end

    always_comb begin
        ref_d = ref_q;
        if (win_end) begin
            unique case (step)
                STEP_UP:   if (ref_q.lvl < MAX_C) ref_d.lvl = ref_q.lvl + 1'b1;
                STEP_DOWN: if (ref_q.lvl > MIN_C) ref_d.lvl = ref_q.lvl - 1'b1;
                default:   ref_d.lvl = ref_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q.lvl <= MID_C;
        end else begin
            ref_q <= ref_d;
        end
    end

    assign ref_code = ref_q.lvl;

    // R6 (and R7): the code stays inside its clamp window.
    assert_ref_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_q.lvl >= MIN_C) && (ref_q.lvl <= MAX_C));

    // R9: between window ends the code is frozen.
    assert_hold_midwindow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(ref_q.lvl));

    // R3: an over-threshold total below the ceiling raises the code by one.
    assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && (win_total > thr_hi) && (ref_q.lvl < MAX_C))
        |=> (ref_q.lvl == REF_W'($past(ref_q.lvl) + 1'b1)));

    // R4: an under-threshold total above the floor lowers the code by one.
    assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && (win_total < thr_lo) && (win_total <= thr_hi) && (ref_q.lvl > MIN_C))
        |=> (ref_q.lvl == REF_W'($past(ref_q.lvl) - 1'b1)));

    // R5: a total inside the inclusive band keeps the code.
    assert_band_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && (win_total >= thr_lo) && (win_total <= thr_hi))
        |=> $stable(ref_q.lvl));

endmodule

// File: rtl/adc_ref_cal.sv
// Top: saturation-percentage reference calibration loop for an I/Q converter pair.
module adc_ref_cal
    import adc_cal_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 3,
    parameter int unsigned WIN_LOG2 = 20,
    parameter int unsigned REF_W    = 5,
    parameter int unsigned REF_MIN  = 8,
    parameter int unsigned REF_MAX  = 24,
    parameter int unsigned REF_MID  = 16,
    localparam int unsigned CNT_W   = WIN_LOG2 + $clog2(CAL_LANES) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] i_code,
    input  logic [SAMPLE_W-1:0] q_code,
    input  logic [CNT_W-1:0]    thr_lo,
    input  logic [CNT_W-1:0]    thr_hi,
    output logic [REF_W-1:0]    ref_code
);

    logic [CAL_LANES*SAMPLE_W-1:0] codes;
    logic [CAL_LANES-1:0]          flags;
    logic                          valid;
    logic                          win_end;
    logic [CNT_W-1:0]              win_total;

    assign codes = {q_code, i_code};

    cal_sat_detect #(
        .SAMPLE_W (SAMPLE_W),
        .LANES    (CAL_LANES)
    ) u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .codes (codes),
        .flags (flags),
        .valid (valid)
    );

    cal_window_acc #(
        .WIN_LOG2 (WIN_LOG2),
        .LANES    (CAL_LANES),
        .CNT_W    (CNT_W)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags     (flags),
        .valid     (valid),
        .win_end   (win_end),
        .win_total (win_total)
    );

    cal_ref_step #(
        .CNT_W   (CNT_W),
        .REF_W   (REF_W),
        .REF_MIN (REF_MIN),
        .REF_MAX (REF_MAX),
        .REF_MID (REF_MID)
    ) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_end   (win_end),
        .win_total (win_total),
        .thr_lo    (thr_lo),
        .thr_hi    (thr_hi),
        .ref_code  (ref_code)
    );

endmodule

// File: tb/adc_ref_cal_tb.sv
module adc_ref_cal_tb;

    localparam int WLOG  = 6;
    localparam int NWIN  = 1 << WLOG;
    localparam int CW    = WLOG + 2;
    localparam int RMID  = 16;
    localparam int RMIN  = 8;
    localparam int RMAX  = 24;
    localparam int TLO   = 10;
    localparam int THI   = 40;

    // Vector: {I hits, Q hits, style, expected ref after window}
    // style[1:0]: 0 -> 111, 1 -> 000, 2 -> alternate; style[2]: hits at window tail
    localparam int NVEC = 9;
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd20, 8'd21, 8'd0, 8'd17},   // R3: 41 > 40
        {8'd20, 8'd20, 8'd1, 8'd17},   // R5: 40 == hi
        {8'd5,  8'd5,  8'd2, 8'd17},   // R5: 10 == lo
        {8'd5,  8'd4,  8'd0, 8'd16},   // R4: 9 < 10
        {8'd0,  8'd0,  8'd0, 8'd15},   // R4: none
        {8'd64, 8'd64, 8'd2, 8'd16},   // R2/R3: full window both lanes
        {8'd30, 8'd0,  8'd1, 8'd16},   // R5: I only
        {8'd0,  8'd41, 8'd5, 8'd17},   // R2/R3: Q tail with 000
        {8'd0,  8'd9,  8'd6, 8'd16}    // R4: tail, alternating
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    i_code = 3'd3;
    logic [2:0]    q_code = 3'd3;
    logic [CW-1:0] thr_lo = CW'(TLO);
    logic [CW-1:0] thr_hi = CW'(THI);
    logic [4:0]    ref_code;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    bit  pend   = 1'b0;
    int  pend_exp;
    string pend_tag;

    always #5 clk = ~clk;

    adc_ref_cal #(
        .WIN_LOG2 (WLOG)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .i_code   (i_code),
        .q_code   (q_code),
        .thr_lo   (thr_lo),
        .thr_hi   (thr_hi),
        .ref_code (ref_code)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: ref_code actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] filler(input int i);
        case (i % 6)
            0: return 3'd1;
            1: return 3'd6;
            2: return 3'd3;
            3: return 3'd4;
            4: return 3'd2;
            default: return 3'd5;
        endcase
    endfunction

    function automatic logic [2:0] rail(input int style, input int i);
        case (style & 3)
            0: return 3'd7;
            1: return 3'd0;
            default: return (i % 2 == 0) ? 3'd7 : 3'd0;
        endcase
    endfunction

    function automatic bit hit(input int n, input int style, input int i);
        if ((style & 4) != 0) return i >= (NWIN - n);
        return i < n;
    endfunction

    // Drives one full window; checks the previous window's result inside it.
    task automatic run_window(input int ni, input int nq, input int style,
                              input int exp, input string tag);
        for (int i = 0; i < NWIN; i++) begin
            if (i == 1 && pend) check(pend_tag, int'(ref_code), pend_exp);
            if (i == NWIN / 2 && pend) check("R9 mid-window hold", int'(ref_code), pend_exp);
            i_code = hit(ni, style, i) ? rail(style, i) : filler(i);
            q_code = hit(nq, style, i) ? rail(style, i + 1) : filler(i + 3);
            @(negedge clk);
        end
        pend     = 1'b1;
        pend_exp = exp;
        pend_tag = tag;
    endtask

    task automatic flush();
        i_code = 3'd3;
        q_code = 3'd4;
        @(negedge clk);
        if (pend) check(pend_tag, int'(ref_code), pend_exp);
        pend = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        pend   = 1'b0;
        i_code = 3'd7;
        q_code = 3'd0;
        repeat (3) @(negedge clk);
        check("R8 reset value", int'(ref_code), RMID);
        i_code = 3'd3;
        q_code = 3'd3;
        rst_n  = 1'b1;
    endtask

    initial begin
        int exp;
        do_reset();

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            run_window(int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]),
                       int'(VEC[v][7:0]), $sformatf("R1/R3/R4/R5 vector %0d", v));
        end
        exp = 16;

        // R6: climb to and sit at the ceiling
        for (int k = 0; k < 10; k++) begin
            exp = (exp < RMAX) ? exp + 1 : RMAX;
            run_window(64, 64, 0, exp, "R6 ceiling clamp");
        end

        // R7: descend to and sit at the floor
        for (int k = 0; k < 20; k++) begin
            exp = (exp > RMIN) ? exp - 1 : RMIN;
            run_window(0, 0, 0, exp, "R7 floor clamp");
        end
        flush();

        // R8: reset in the middle of a window, then realigned first window
        for (int i = 0; i < 20; i++) begin
            i_code = 3'd7;
            q_code = 3'd7;
            @(negedge clk);
        end
        do_reset();
        check("R8 after release", int'(ref_code), RMID);
        run_window(21, 20, 2, 17, "R8 first window after reset");
        run_window(20, 20, 5, 17, "R2 tail window band hold");
        flush();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule